// File: doc/BRIEF.md
# RTC Interrupt Flag Controller

This block gathers six one-cycle event strobes from a real-time clock core and turns them into a single active-low interrupt request. The six sources are periodic tick, alarm match, update ended, RAM cleared, wake-up alarm and kickstart. Every source has a sticky flag and an enable bit. A flag is raised whether or not its enable is set, so software can poll sources that it has masked. The interrupt line is driven low only while at least one flag is set together with its enable.

The flags are split into two tiers. The primary tier holds periodic, alarm and update-ended. It is read through a flag register whose top bit is a summary request bit, and reading that register clears the primary tier. The extended tier holds RAM-clear, wake-up and kickstart. It has its own enable register and its own flag register, and software clears an extended flag by writing 0 to its bit.

Software reaches the four registers through a byte-wide port with a 2-bit address and separate read and write strobes. Read data is combinational from the address, so the value seen during a read cycle is the value before any clear that the read causes. The port has no back-pressure: each access completes in one cycle. The event inputs are plain strobes and have no handshake.

Top module: `rtc_irq_ctrl`

## Requirements
- R1: After reset every flag and every enable is 0, irq_n is 1, and all four registers read 0x00.
- R2: Address 0 is the primary enable register: bit 6 enables periodic, bit 5 enables alarm and bit 4 enables update-ended. The register is writable and reads back; all other bits read 0.
- R3: Address 1 is the primary flag register: bit 7 is the summary bit, bit 6 periodic, bit 5 alarm and bit 4 update-ended. Bits 3..0 always read 0. Writes to this address have no effect.
- R4: Address 2 is the extended flag register: bit 2 is RAM-clear, bit 1 wake-up and bit 0 kickstart. Bits 7..3 read 0.
- R5: Address 3 is the extended enable register: bits 2, 1 and 0 enable RAM-clear, wake-up and kickstart. It reads back, and bits 7..3 read 0.
- R6: A strobe sets its flag at the clock edge where it is sampled, whatever the enable. The flag then holds until it is cleared.
- R7: The summary bit is 1 exactly when some primary flag and its enable, or some extended flag and its enable, are both 1. irq_n is the inverse of the summary bit.
- R8: A read of address 1 returns the current value and clears the three primary flags at that clock edge. Extended flags are not affected.
- R9: A write to address 2 clears each extended flag whose data bit is 0 and leaves unchanged each flag whose data bit is 1. Software can never set a flag.
- R10: A strobe that arrives in the same cycle as a clearing read or a clearing write leaves its flag set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (clears primary flags on address 1) |
| reg_addr | input | 2 | Register select |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for reg_addr, combinational |
| ev_periodic | input | 1 | Periodic tick strobe |
| ev_alarm | input | 1 | Alarm match strobe |
| ev_update | input | 1 | Update-ended strobe |
| ev_ramclr | input | 1 | RAM-cleared strobe |
| ev_wake | input | 1 | Wake-up alarm strobe |
| ev_kick | input | 1 | Kickstart strobe |
| irq_n | output | 1 | Active-low interrupt request |

## Verification
A flag can be cleared by software and set by its event strobe in the same cycle. For the primary tier the clear is a read of address 1; for the extended tier it is a write of 0 to address 2. The bench drives the strobe in the same cycle as each of these accesses. It checks that the read returns the value from before the event, and that the flag reads 1 afterwards. It also checks that a read of the primary flags in the same cycle as extended flags are pending leaves the extended flags untouched.

// File: rtl/rtc_irq_pkg.sv
package rtc_irq_pkg;
  localparam int ADDR_W = 2;
  localparam int DATA_W = 8;
  localparam int PRI_N  = 3;   // periodic, alarm, update-ended
  localparam int EXT_N  = 3;   // ram-clear, wake-up, kickstart

  // bit positions inside the primary registers
  localparam int PRI_LSB = 4;
  localparam int SUM_BIT = 7;

  typedef enum logic [ADDR_W-1:0] {
    RA_PEN  = 2'd0,
    RA_PFLG = 2'd1,
    RA_XFLG = 2'd2,
    RA_XEN  = 2'd3
  } reg_sel_e;
endpackage

// File: rtl/irq_enable_reg.sv
module irq_enable_reg #(
  parameter int W = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         we,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] en
);
  always_ff @(posedge clk) begin
    if (!rst_n)  en <= '0;
    else if (we) en <= wdata;
  end

  AST_EN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !we |=> $stable(en)); // R2
endmodule

// File: rtl/irq_flag_bank.sv
module irq_flag_bank #(
  parameter int W = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] set,
  input  logic [W-1:0] clr,
  output logic [W-1:0] flag
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    always_ff @(posedge clk) begin
      if (!rst_n)      flag[i] <= 1'b0;
      else if (set[i]) flag[i] <= 1'b1;   // event outranks clear
      else if (clr[i]) flag[i] <= 1'b0;
    end

    AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
      set[i] |=> flag[i]); // R10
    AST_CLR_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
      (clr[i] && !set[i]) |=> !flag[i]); // R8
    AST_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      (flag[i] && !clr[i]) |=> flag[i]); // R6
  end
endmodule

// File: rtl/irq_summary.sv
module irq_summary #(
  parameter int PW = 3,
  parameter int XW = 3
) (
  input  logic [PW-1:0] pflag,
  input  logic [PW-1:0] pen,
  input  logic [XW-1:0] xflag,
  input  logic [XW-1:0] xen,
  output logic          summary
);
  always_comb summary = (|(pflag & pen)) | (|(xflag & xen));
endmodule

// File: rtl/rtc_irq_ctrl.sv
module rtc_irq_ctrl
  import rtc_irq_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic              ev_periodic,
  input  logic              ev_alarm,
  input  logic              ev_update,
  input  logic              ev_ramclr,
  input  logic              ev_wake,
  input  logic              ev_kick,
  output logic              irq_n
);
  localparam int PRI_MSB = PRI_LSB + PRI_N - 1;

  logic [PRI_N-1:0] pen, pflag, pset, pclr;
  logic [EXT_N-1:0] xen, xflag, xset, xclr;
  logic             summary;
  logic             unused_wbits;

  assign pset = {ev_periodic, ev_alarm, ev_update};
  assign xset = {ev_ramclr, ev_wake, ev_kick};
  assign unused_wbits = ^{reg_wdata[DATA_W-1], reg_wdata[PRI_LSB-1:EXT_N]};

  // clear vectors: read-to-clear for the primary tier, write-zero for extended
  always_comb begin
    pclr = {PRI_N{reg_rd && (reg_addr == RA_PFLG)}};
    xclr = (reg_wr && (reg_addr == RA_XFLG)) ? ~reg_wdata[EXT_N-1:0] : '0;
  end

  irq_enable_reg #(.W(PRI_N)) u_pen (
    .clk(clk), .rst_n(rst_n),
    .we(reg_wr && (reg_addr == RA_PEN)),
    .wdata(reg_wdata[PRI_MSB:PRI_LSB]), .en(pen));

  irq_enable_reg #(.W(EXT_N)) u_xen (
    .clk(clk), .rst_n(rst_n),
    .we(reg_wr && (reg_addr == RA_XEN)),
    .wdata(reg_wdata[EXT_N-1:0]), .en(xen));

  irq_flag_bank #(.W(PRI_N)) u_pflag (
    .clk(clk), .rst_n(rst_n), .set(pset), .clr(pclr), .flag(pflag));

  irq_flag_bank #(.W(EXT_N)) u_xflag (
    .clk(clk), .rst_n(rst_n), .set(xset), .clr(xclr), .flag(xflag));

  irq_summary #(.PW(PRI_N), .XW(EXT_N)) u_sum (
    .pflag(pflag), .pen(pen), .xflag(xflag), .xen(xen), .summary(summary));

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      RA_PEN:  reg_rdata[PRI_MSB:PRI_LSB] = pen;
      RA_PFLG: begin
        reg_rdata[PRI_MSB:PRI_LSB] = pflag;
        reg_rdata[SUM_BIT]         = summary;
      end
      RA_XFLG: reg_rdata[EXT_N-1:0] = xflag;
      RA_XEN:  reg_rdata[EXT_N-1:0] = xen;
      default: reg_rdata = '0;
    endcase
  end

  assign irq_n = ~summary;

  AST_LOW_NIBBLE: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_addr == RA_PFLG) |-> (reg_rdata[PRI_LSB-1:0] == '0)); // R3
  AST_IRQ_HAS_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_n |-> ((|pflag) || (|xflag))); // R7
  AST_EXT_KEEP_ON_READ: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rd && !reg_wr && (reg_addr == RA_PFLG) && (xset == '0))
      |=> (xflag == $past(xflag))); // R8
  AST_NO_SOFT_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (xset == '0) |=> ((xflag & ~$past(xflag)) == '0)); // R9
endmodule

// File: tb/rtc_irq_ctrl_bench.sv
module rtc_irq_ctrl_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       reg_wr = 1'b0, reg_rd = 1'b0;
  logic [1:0] reg_addr = '0;
  logic [7:0] reg_wdata = '0;
  logic [7:0] reg_rdata;
  logic [5:0] ev = '0;   // {periodic, alarm, update, ramclr, wake, kick}
  logic       irq_n;
  int         errors = 0, checks = 0;
  logic [7:0] got;

  always #10 clk = ~clk;   // 50 MHz

  rtc_irq_ctrl u_rtc_irq_ctrl (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .ev_periodic(ev[5]), .ev_alarm(ev[4]), .ev_update(ev[3]),
    .ev_ramclr(ev[2]), .ev_wake(ev[1]), .ev_kick(ev[0]), .irq_n(irq_n));

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d, input logic [5:0] e = '0);
    @(negedge clk); reg_wr = 1'b1; reg_addr = a; reg_wdata = d; ev = e;
    @(negedge clk); reg_wr = 1'b0; ev = '0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d, input logic [5:0] e = '0);
    @(negedge clk); reg_rd = 1'b1; reg_addr = a; ev = e;
    #1 d = reg_rdata;
    @(negedge clk); reg_rd = 1'b0; ev = '0;
  endtask

  task automatic fire(input logic [5:0] e);
    @(negedge clk); ev = e;
    @(negedge clk); ev = '0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    chk("R1 irq_n", {7'd0, irq_n}, 8'h01);
    for (int a = 0; a < 4; a++) begin
      rd(a[1:0], got); chk("R1 reg", got, 8'h00);
    end
    // R2 / R5 register readback with reserved bits
    wr(2'd0, 8'hFF); rd(2'd0, got); chk("R2 pen", got, 8'h70);
    wr(2'd3, 8'hFF); rd(2'd3, got); chk("R5 xen", got, 8'h07);
    wr(2'd0, 8'h00); wr(2'd3, 8'h00);
    // R3 write to primary flags ignored
    wr(2'd1, 8'hFF); rd(2'd1, got); chk("R3 write ignored", got, 8'h00);
    fire(6'b010000);
    wr(2'd1, 8'h00); rd(2'd1, got); chk("R3 write keeps flag", got, 8'h20);

    // R6 R7 R8: sweep primary enables x primary events
    for (int en = 0; en < 8; en++) begin
      for (int e = 0; e < 8; e++) begin
        logic s;
        s = |(en[2:0] & e[2:0]);
        wr(2'd0, {1'b0, en[2:0], 4'b0});
        fire({e[2:0], 3'b0});
        chk("R7 irq_n primary", {7'd0, irq_n}, {7'd0, ~s});
        rd(2'd1, got); chk("R6 R3 pflag", got, {s, e[2:0], 4'b0});
        chk("R8 irq released", {7'd0, irq_n}, 8'h01);
        rd(2'd1, got); chk("R8 cleared", got, 8'h00);
      end
    end
    wr(2'd0, 8'h00);

    // R4 R7 R8 R9: sweep extended enables x extended events
    for (int en = 0; en < 8; en++) begin
      for (int e = 0; e < 8; e++) begin
        logic s;
        s = |(en[2:0] & e[2:0]);
        wr(2'd3, {5'b0, en[2:0]});
        fire({3'b0, e[2:0]});
        chk("R7 irq_n ext", {7'd0, irq_n}, {7'd0, ~s});
        rd(2'd2, got); chk("R4 xflag", got, {5'b0, e[2:0]});
        rd(2'd1, got); chk("R7 summary ext", got, {s, 7'b0});
        rd(2'd2, got); chk("R8 ext kept", got, {5'b0, e[2:0]});
        wr(2'd2, 8'h00);
        rd(2'd2, got); chk("R9 all cleared", got, 8'h00);
        chk("R9 irq released", {7'd0, irq_n}, 8'h01);
      end
    end

    // R9 partial clear, ones leave bits alone
    fire(6'b000111);
    wr(2'd2, 8'hFD); rd(2'd2, got); chk("R9 partial", got, 8'h05);
    wr(2'd2, 8'hFF); rd(2'd2, got); chk("R9 ones no effect", got, 8'h05);
    wr(2'd2, 8'h00);

    // R10 event with clearing read
    wr(2'd0, 8'h40);
    fire(6'b100000);
    rd(2'd1, got, 6'b100000); chk("R10 read value", got, 8'hC0);
    rd(2'd1, got); chk("R10 flag survives read", got, 8'hC0);
    chk("R10 irq_n", {7'd0, irq_n}, 8'h01);
    // R10 event with clearing write
    fire(6'b000001);
    wr(2'd2, 8'h00, 6'b000001);
    rd(2'd2, got); chk("R10 flag survives write", got, 8'h01);
    wr(2'd2, 8'h00); rd(2'd2, got); chk("R9 final clear", got, 8'h00);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule